// File: doc/BRIEF.md
# Two-Wire Serial Register Target

This block is a target on a two-wire serial bus (open-drain clock and data lines, with the clock always driven by an external master). It gives that master access to a bank of byte-wide registers. Both bus lines are oversampled in the system clock domain. From the oversampled lines the block recognises start, repeated-start and stop conditions, compares the incoming device address against a fixed value and steps through the bytes of a transfer. The block never drives the clock line. It pulls the data line low through an output-enable pin and otherwise leaves it released.

A write transfer begins with the device address. The first data byte after it sets a register pointer, and each later data byte is stored at the pointer. A read transfer returns the contents of the register at the pointer. The pointer survives a repeated start, so the usual sequence works: address and write bit, pointer byte, repeated start, address and read bit, then data out. On the chip side, every register is visible on a flat parallel bus. A single-cycle strobe with an index marks each register updated from the bus. Data moves at the pace the bus master sets; no valid/ready flow control exists on either side. The strobe is a pure notification, and neither side can apply back-pressure because the target does not stretch the clock.

Top module: `serial_reg_target`

## Requirements
- R1: While reset is asserted, and directly after it, `sda_oe` and `wr_strobe` are 0 and every register reads 0 on `reg_flat`. Register i sits at bits [8i+7:8i].
- R2: After a start, bits arrive MSB first. The first byte is the 7-bit device address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). When the address equals `DEV_ADDR` (default 0x2A), the target pulls SDA low for the ninth clock.
- R3: When the address does not match, the target gives no acknowledge and writes no register until the next start or stop, whatever bytes follow.
- R4: In a write transfer, the first data byte loads its low 4 bits into the register pointer. Each later byte is stored in the register at the pointer. The target acknowledges every one of these bytes.
- R5: Each register update from the bus produces `wr_strobe` high for exactly one cycle. In that cycle `wr_index` carries the register number and the register already holds the new value. The strobe coincides with the target driving the acknowledge.
- R6: The pointer increments after each data byte that is stored or read, and it wraps from 15 to 0.
- R7: The pointer is kept across a repeated start. A read transfer that follows returns the register at the pointer, MSB first.
- R8: In a read, a master acknowledge (SDA low on the ninth clock) makes the target send the next register. A master not-acknowledge makes it release SDA for all later clocks until the next start.
- R9: A start clears the bit and byte tracking from any state, including the middle of a byte, and discards the partial byte. A stop returns the target to idle with SDA released.
- R10: `sda_oe` only rises while SCL is low, one system clock after the synchronized SCL falling edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull the data line low, 0 = release it |
| reg_flat | output | NREGS*8 | All registers side by side, register 0 in the low byte |
| wr_strobe | output | 1 | One-cycle pulse per register written from the bus |
| wr_index | output | $clog2(NREGS) | Number of the register just written |

## Verification
The hardest situations to reach are the ones that cut a transfer short. One is a repeated start placed after only half of a data byte. The other is the period after a master not-acknowledge, when the target must stay silent while the master keeps clocking. The bench reaches both through a bus-master model built from bit-level tasks. The model can stop a byte after any number of bits and issue a start from the clock-low phase. After a not-acknowledge it reads a further byte and expects all ones on the wired-AND data line. A lost partial byte shows up as an untouched register, and a target that keeps driving shows up as a zero bit in that byte.

// File: rtl/srt_pkg.sv
package srt_pkg;

  // Byte width is fixed by the bus protocol.
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_ADDR,   // shifting in the address byte
    ST_AACK,   // driving the address acknowledge
    ST_WBYTE,  // shifting in a data byte
    ST_WACK,   // driving the data acknowledge
    ST_RBYTE,  // shifting out a register
    ST_RACK,   // listening for the master acknowledge
    ST_SKIP    // not addressed or read ended: stay silent
  } srt_state_e;

endpackage

// File: rtl/srt_line.sv
// Synchronizer plus one sample of history for one bus line.
module srt_line #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic cur,
  output logic prv
);
  logic [SYNC:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;   // released bus lines idle high
    else        sh <= {sh[SYNC-1:0], din};
  end

  assign cur = sh[SYNC-1];
  assign prv = sh[SYNC];
endmodule

// File: rtl/srt_bank.sv
// Register bank: one write port, one read port, flat view, update strobe.
module srt_bank #(
  parameter int NREGS = 16,
  parameter int BW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [BW-1:0]       wdata,
  input  logic [AW-1:0]       raddr,
  output logic [BW-1:0]       rdata,
  output logic [NREGS*BW-1:0] flat,
  output logic                strobe,
  output logic [AW-1:0]       strobe_idx
);
  logic [BW-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         regs[g] <= '0;
      else if (we && waddr == AW'(g))     regs[g] <= wdata;
    end
    assign flat[g*BW +: BW] = regs[g];
  end

  assign rdata = regs[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe     <= 1'b0;
      strobe_idx <= '0;
    end else begin
      strobe     <= we;
      strobe_idx <= waddr;
    end
  end
endmodule

// File: rtl/serial_reg_target.sv
module serial_reg_target
  import srt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NREGS    = 16,
  parameter int         SYNC     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_in,
  input  logic                       sda_in,
  output logic                       sda_oe,
  output logic [NREGS*BYTE_W-1:0]    reg_flat,
  output logic                       wr_strobe,
  output logic [$clog2(NREGS)-1:0]   wr_index
);
  localparam int AW = $clog2(NREGS);

  // ---- line conditioning ----
  logic scl_c, scl_p, sda_c, sda_p;

  srt_line #(.SYNC(SYNC)) u_scl (.clk(clk), .rst_n(rst_n), .din(scl_in), .cur(scl_c), .prv(scl_p));
  srt_line #(.SYNC(SYNC)) u_sda (.clk(clk), .rst_n(rst_n), .din(sda_in), .cur(sda_c), .prv(sda_p));

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  =  scl_c & ~scl_p;
  assign scl_fall  = ~scl_c &  scl_p;
  assign start_det =  scl_c &  scl_p &  sda_p & ~sda_c;
  assign stop_det  =  scl_c &  scl_p & ~sda_p &  sda_c;

  // ---- protocol state ----
  srt_state_e        state;
  logic [3:0]        cnt;       // bits done in the current byte, 0..8
  logic [BYTE_W-1:0] shreg;     // incoming byte
  logic [BYTE_W-1:0] txd;       // outgoing byte
  logic [AW-1:0]     ptr;
  logic              ptr_load;  // next written byte is the pointer
  logic              rw_q;
  logic              mack_q;    // master acknowledged the last read byte
  logic              oe_q;

  logic              bank_we;
  logic [BYTE_W-1:0] rdata;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(NREGS-1)) ? '0 : p + 1'b1;
  endfunction

  assign bank_we = !start_det && !stop_det && scl_fall && state == ST_WBYTE &&
                   cnt == 4'd8 && !ptr_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      txd      <= '0;
      ptr      <= '0;
      ptr_load <= 1'b1;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      ptr_load <= 1'b1;
      oe_q     <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      oe_q     <= 1'b0;
    end else if (scl_rise) begin
      unique case (state)
        ST_ADDR, ST_WBYTE: begin
          shreg <= {shreg[BYTE_W-2:0], sda_c};
          cnt   <= cnt + 1'b1;
        end
        ST_RBYTE: cnt    <= cnt + 1'b1;
        ST_RACK:  mack_q <= ~sda_c;
        default: ;
      endcase
    end else if (scl_fall) begin
      unique case (state)
        ST_ADDR: if (cnt == 4'd8) begin
          if (shreg[7:1] == DEV_ADDR) begin
            state <= ST_AACK;
            oe_q  <= 1'b1;
            rw_q  <= shreg[0];
          end else begin
            state <= ST_SKIP;
          end
        end
        ST_AACK: begin
          cnt <= '0;
          if (rw_q) begin
            state <= ST_RBYTE;
            txd   <= rdata;
            oe_q  <= ~rdata[BYTE_W-1];
          end else begin
            state <= ST_WBYTE;
            oe_q  <= 1'b0;
          end
        end
        ST_WBYTE: if (cnt == 4'd8) begin
          state <= ST_WACK;
          oe_q  <= 1'b1;
          if (ptr_load) begin
            ptr      <= shreg[AW-1:0];
            ptr_load <= 1'b0;
          end else begin
            ptr <= ptr_next(ptr);
          end
        end
        ST_WACK: begin
          state <= ST_WBYTE;
          cnt   <= '0;
          oe_q  <= 1'b0;
        end
        ST_RBYTE: begin
          if (cnt == 4'd8) begin
            state <= ST_RACK;
            oe_q  <= 1'b0;
            ptr   <= ptr_next(ptr);
          end else begin
            oe_q  <= ~txd[3'(4'd7 - cnt)];
          end
        end
        ST_RACK: begin
          if (mack_q) begin
            state <= ST_RBYTE;
            cnt   <= '0;
            txd   <= rdata;
            oe_q  <= ~rdata[BYTE_W-1];
          end else begin
            state <= ST_SKIP;
            oe_q  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;

  srt_bank #(.NREGS(NREGS), .BW(BYTE_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (bank_we),
    .waddr      (ptr),
    .wdata      (shreg),
    .raddr      (ptr),
    .rdata      (rdata),
    .flat       (reg_flat),
    .strobe     (wr_strobe),
    .strobe_idx (wr_index)
  );
endmodule

// File: rtl/srt_checker.sv
module srt_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_oe,
  input logic wr_strobe
);
  // R1: quiet outputs while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!sda_oe && !wr_strobe));

  // R10: the data line is only pulled low while the clock line is low
  a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);

  // R5: one strobe per update
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  // R5: an update coincides with the target acknowledging the byte
  a_r5_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> sda_oe);
endmodule

bind serial_reg_target srt_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_in    (scl_in),
  .sda_oe    (sda_oe),
  .wr_strobe (wr_strobe)
);

// File: tb/serial_reg_target_test.sv
module serial_reg_target_test;
  localparam int Q     = 10;       // system clocks per quarter bus bit
  localparam int NREGS = 16;
  localparam logic [6:0] ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_strobe;
  logic [3:0] wr_index;
  logic [NREGS*8-1:0] reg_flat;
  logic sda_in;

  int n_chk = 0, n_fail = 0;
  int strobes = 0;
  logic [3:0] last_idx = '0;
  int oe_high_rise = 0;
  logic oe_prev = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  assign sda_in = sda_m & ~sda_oe;   // wired-AND bus

  serial_reg_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_in),
    .sda_oe(sda_oe), .reg_flat(reg_flat), .wr_strobe(wr_strobe), .wr_index(wr_index)
  );

  always @(negedge clk) begin
    if (wr_strobe) begin
      strobes  <= strobes + 1;
      last_idx <= wr_index;
    end
    if (sda_oe && !oe_prev && scl_m) oe_high_rise <= oe_high_rise + 1;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] rg(input int i);
    return reg_flat[i*8 +: 8];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_wr(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bit_rd(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_in; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic byte_wr(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_wr(d[i]);
    bit_rd(b);
    ack = ~b;
  endtask

  task automatic byte_rd(output logic [7:0] d, input logic master_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_rd(b);
      d[i] = b;
    end
    bit_wr(~master_ack);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 oe in reset", sda_oe, 0);
    check("R1 strobe in reset", wr_strobe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 oe after reset", sda_oe, 0);
    check("R1 regs zero", (reg_flat == '0) ? 1 : 0, 1);
  endtask

  task automatic t_write();
    logic ack;
    int s0;
    s0 = strobes;
    bus_start();
    byte_wr({ADDR, 1'b0}, ack);  check("R2 address ack", ack, 1);
    byte_wr(8'h03, ack);         check("R4 pointer ack", ack, 1);
    check("R5 no strobe for pointer", strobes - s0, 0);
    byte_wr(8'hA5, ack);         check("R4 data ack", ack, 1);
    check("R5 strobe index", last_idx, 3);
    byte_wr(8'h5C, ack);         check("R4 data ack 2", ack, 1);
    bus_stop();
    check("R9 released after stop", sda_oe, 0);
    check("R4 reg3", rg(3), 8'hA5);
    check("R6 reg4 after increment", rg(4), 8'h5C);
    check("R5 strobe count", strobes - s0, 2);
    check("R5 last strobe index", last_idx, 4);
  endtask

  task automatic t_wrap();
    logic ack;
    bus_start();
    byte_wr({ADDR, 1'b0}, ack);
    byte_wr(8'h0F, ack);
    byte_wr(8'h11, ack);
    byte_wr(8'h22, ack);
    bus_stop();
    check("R6 reg15", rg(15), 8'h11);
    check("R6 wrap to reg0", rg(0), 8'h22);
  endtask

  task automatic t_mismatch();
    logic ack;
    int s0;
    s0 = strobes;
    bus_start();
    byte_wr({ADDR + 7'd1, 1'b0}, ack); check("R3 no ack on mismatch", ack, 0);
    byte_wr(8'h01, ack);               check("R3 no ack on pointer", ack, 0);
    byte_wr(8'h77, ack);               check("R3 no ack on data", ack, 0);
    bus_stop();
    check("R3 reg1 untouched", rg(1), 8'h00);
    check("R3 no strobe", strobes - s0, 0);
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] d;
    bus_start();
    byte_wr({ADDR, 1'b0}, ack);
    byte_wr(8'h03, ack);
    bus_start();                         // repeated start, no stop
    byte_wr({ADDR, 1'b1}, ack);  check("R2 read address ack", ack, 1);
    byte_rd(d, 1'b1);            check("R7 read reg3 after repeated start", d, 8'hA5);
    byte_rd(d, 1'b0);            check("R8 read next after master ack", d, 8'h5C);
    byte_rd(d, 1'b0);            check("R8 released after master nack", d, 8'hFF);
    bus_stop();
    check("R9 released after read stop", sda_oe, 0);
  endtask

  task automatic t_restart_mid();
    logic ack;
    bus_start();
    byte_wr({ADDR, 1'b0}, ack);
    byte_wr(8'h05, ack);
    for (int i = 0; i < 4; i++) bit_wr(1'b1);   // half a data byte
    bus_start();
    byte_wr({ADDR, 1'b0}, ack);  check("R9 ack after mid-byte restart", ack, 1);
    byte_wr(8'h06, ack);
    byte_wr(8'h3C, ack);
    bus_stop();
    check("R9 partial byte discarded", rg(5), 8'h00);
    check("R9 reg6 written", rg(6), 8'h3C);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    t_reset();
    t_write();
    t_wrap();
    t_mismatch();
    t_read();
    t_restart_mid();
    check("R10 oe never rises with scl high", oe_high_rise, 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule